// File: doc/BRIEF.md
# Card Host Status and Interrupt Register Bank

This block is the register-side status and interrupt logic of a memory-card host controller. A sticky event word collects one-cycle pulses from the command and data engines: CRC failures, timeouts, underrun or overrun, response end, command sent, data end and block end. Each bit stays set until software writes a one to its position in the clear register. Above the sticky field, a set of live activity and FIFO-level flags from the data path is shown as it is, and no write changes them. Two mask registers each select which status bits drive one level-sensitive interrupt line.

The bank also holds the plain configuration registers: power, clock, data length and data control. It shows the remaining transfer length rounded up to whole 32-bit words. It exposes eight identification bytes at the top of a 4 KiB window and maps a sixteen-word window onto a single FIFO data port. A small two-state machine, RUN and HOLD, implements refill deferral. Reading FIFO data moves it from RUN to HOLD, which raises `hold_refill` so the data engine stops. A later read of status or of the word count moves it back from HOLD to RUN. That read still returns the value captured before the engine resumes.

Register access uses a simple strobe port. Read data is registered and appears on the cycle after the read strobe. It keeps that value until the next read.

Top module: `stat_irq_bank`

## Requirements
- R1: `irq0` is high exactly when the bitwise AND of the 22-bit status word and mask 0 (offset 0x18) is nonzero, and `irq1` is the same with mask 1 (offset 0x1C).
- R2: A write to the clear register (offset 0x14) clears only those sticky bits 10:0 whose write-data bit is 1. Status bits 21:11 are unaffected, and status bit 9 always reads 0.
- R3: A pulse on `evt_set[k]` sets status bit k (k in 0..8 or 10) on the next edge, and the bit stays set until cleared. If a set and a clear of the same bit arrive in the same cycle, the set wins.
- R4: A read of the word-count register (offset 0x20) returns (`bytes_left` + 3) >> 2.
- R5: Any read in the FIFO window puts the machine into HOLD, which drives `hold_refill` high. The next read of status (offset 0x10) or word count returns the value from before the release and returns the machine to RUN. Other reads do not change the state.
- R6: Reads of 0xFE0 to 0xFFC return identification byte (offset - 0xFE0) >> 2, taken from parameter `ID_BYTES` bits 8k+7:8k, in data bits 7:0.
- R7: Power (0x00), clock (0x04) and data control (0x0C) keep only write-data bits 7:0. Data length (0x08) keeps bits 15:0.
- R8: Every word address 0x80 to 0xBC is the FIFO data port. A read there pulses `fifo_pop` in that cycle and returns `fifo_rdata` on the next cycle. A write there pulses `fifo_push` with `fifo_wdata` equal to the write data.
- R9: Reset clears the sticky status, both masks, the configuration registers, the read data and the HOLD state, so both interrupts are low.
- R10: Read data appears one cycle after the read strobe and holds until the next read. An unmapped offset reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_set | input | 11 | Event pulses for sticky bits 10:0 |
| lvl_flags | input | 11 | Live activity/FIFO-level flags, status bits 21:11 |
| bytes_left | input | 16 | Remaining transfer byte count |
| fifo_rdata | input | 32 | Word at the FIFO head |
| fifo_pop | output | 1 | FIFO read strobe |
| fifo_push | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | Word to push |
| hold_refill | output | 1 | High in HOLD: the data engine must not refill |
| irq0 | output | 1 | Interrupt line for mask 0 |
| irq1 | output | 1 | Interrupt line for mask 1 |

## Verification
The interrupt function is exercised with masks that select only sticky bits and then only live flags. Events are raised and cleared separately, and a set and a clear of one bit are applied in the same cycle, which shows whether the set or the clear takes precedence. Clear patterns that reach bits above 10 show whether the live field is protected. The word-count read uses byte counts of 0, 1, 4, 5 and 0xFFFF to expose off-by-one rounding. FIFO reads at both ends of the window, followed by an unrelated read, a status read and a count read, separate a release on any read from a release on the correct reads only.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int EVT_W  = 11;
    localparam int LVL_W  = 11;
    localparam int CNT_W  = 16;
    localparam int STAT_W = EVT_W + LVL_W;

    localparam logic [ADDR_W-1:0] A_POWER  = 12'h000;
    localparam logic [ADDR_W-1:0] A_CLOCK  = 12'h004;
    localparam logic [ADDR_W-1:0] A_LENGTH = 12'h008;
    localparam logic [ADDR_W-1:0] A_DCTRL  = 12'h00C;
    localparam logic [ADDR_W-1:0] A_STATUS = 12'h010;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 12'h014;
    localparam logic [ADDR_W-1:0] A_MASK0  = 12'h018;
    localparam logic [ADDR_W-1:0] A_MASK1  = 12'h01C;
    localparam logic [ADDR_W-1:0] A_WCOUNT = 12'h020;
    localparam logic [ADDR_W-1:0] A_FIFO_LO = 12'h080;
    localparam logic [ADDR_W-1:0] A_FIFO_HI = 12'h0BC;
    localparam logic [ADDR_W-1:0] A_ID_LO   = 12'hFE0;

    // bit 9 of the sticky field has no source
    localparam logic [EVT_W-1:0] EVT_LIVE = 11'h5FF;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } hold_state_t;
endpackage

// File: rtl/stat_sticky.sv
module stat_sticky #(
    parameter int W = 11,
    parameter logic [W-1:0] LIVE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_pulse,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] sticky_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= '0;
        end else begin
            // a new event in the same cycle outranks the clear
            sticky_q <= (sticky_q & ~clr_bits) | (set_pulse & LIVE);
        end
    end
endmodule

// File: rtl/stat_hold_fsm.sv
module stat_hold_fsm
    import stat_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_rd,
    input  logic release_rd,
    output logic hold
);
    hold_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (fifo_rd)    state_d = ST_HOLD;
            ST_HOLD: if (release_rd) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        hold = (state_q == ST_HOLD);
    end
endmodule

// File: rtl/stat_read_mux.sv
module stat_read_mux
    import stat_irq_pkg::*;
#(
    parameter logic [63:0] ID_BYTES = 64'h0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [STAT_W-1:0] status,
    input  logic [DATA_W-1:0] mask0,
    input  logic [DATA_W-1:0] mask1,
    input  logic [7:0]        power,
    input  logic [7:0]        clock,
    input  logic [15:0]       length,
    input  logic [7:0]        dctrl,
    input  logic [CNT_W-1:0]  bytes_left,
    input  logic [DATA_W-1:0] fifo_word,
    input  logic              in_fifo,
    input  logic              in_id,
    output logic [DATA_W-1:0] rdata
);
    localparam int CW = CNT_W + 1;
    logic [CW-1:0] words;
    logic [2:0]    id_idx;

    always_comb begin
        words  = ({1'b0, bytes_left} + CW'(3)) >> 2;
        id_idx = addr[4:2];
        rdata  = '0;
        if (in_fifo) begin
            rdata = fifo_word;
        end else if (in_id) begin
            rdata = DATA_W'(ID_BYTES[id_idx*8 +: 8]);
        end else begin
            unique case (addr)
                A_POWER:  rdata = DATA_W'(power);
                A_CLOCK:  rdata = DATA_W'(clock);
                A_LENGTH: rdata = DATA_W'(length);
                A_DCTRL:  rdata = DATA_W'(dctrl);
                A_STATUS: rdata = DATA_W'(status);
                A_MASK0:  rdata = mask0;
                A_MASK1:  rdata = mask1;
                A_WCOUNT: rdata = DATA_W'(words);
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/stat_irq_bank.sv
module stat_irq_bank
    import stat_irq_pkg::*;
#(
    parameter logic [63:0] ID_BYTES = 64'hC419_E77E_0001_3C5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EVT_W-1:0]  evt_set,
    input  logic [LVL_W-1:0]  lvl_flags,
    input  logic [CNT_W-1:0]  bytes_left,
    input  logic [DATA_W-1:0] fifo_rdata,
    output logic              fifo_pop,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              hold_refill,
    output logic              irq0,
    output logic              irq1
);
    logic              in_fifo, in_id;
    logic [EVT_W-1:0]  clr_bits, sticky_q;
    logic [STAT_W-1:0] status;
    logic [DATA_W-1:0] mask0_q, mask1_q, rd_next;
    logic [7:0]        power_q, clock_q, dctrl_q;
    logic [15:0]       length_q;

    always_comb begin
        in_fifo  = (reg_addr >= A_FIFO_LO) && (reg_addr <= A_FIFO_HI) && (reg_addr[1:0] == 2'b00);
        in_id    = (reg_addr >= A_ID_LO);
        clr_bits = (reg_wr && reg_addr == A_CLEAR) ? reg_wdata[EVT_W-1:0] : '0;
        status   = {lvl_flags, sticky_q};
        fifo_pop   = reg_rd && in_fifo;
        fifo_push  = reg_wr && in_fifo;
        fifo_wdata = reg_wdata;
        irq0 = |(DATA_W'(status) & mask0_q);
        irq1 = |(DATA_W'(status) & mask1_q);
    end

    stat_sticky #(.W(EVT_W), .LIVE(EVT_LIVE)) u_sticky (
        .clk(clk), .rst_n(rst_n), .set_pulse(evt_set),
        .clr_bits(clr_bits), .sticky_q(sticky_q)
    );

    stat_hold_fsm u_hold (
        .clk(clk), .rst_n(rst_n),
        .fifo_rd(fifo_pop),
        .release_rd(reg_rd && (reg_addr == A_STATUS || reg_addr == A_WCOUNT)),
        .hold(hold_refill)
    );

    stat_read_mux #(.ID_BYTES(ID_BYTES)) u_mux (
        .addr(reg_addr), .status(status), .mask0(mask0_q), .mask1(mask1_q),
        .power(power_q), .clock(clock_q), .length(length_q), .dctrl(dctrl_q),
        .bytes_left(bytes_left), .fifo_word(fifo_rdata),
        .in_fifo(in_fifo), .in_id(in_id), .rdata(rd_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask0_q   <= '0;
            mask1_q   <= '0;
            power_q   <= '0;
            clock_q   <= '0;
            dctrl_q   <= '0;
            length_q  <= '0;
            reg_rdata <= '0;
        end else begin
            if (reg_rd) reg_rdata <= rd_next;
            if (reg_wr) begin
                unique case (reg_addr)
                    A_MASK0:  mask0_q  <= reg_wdata;
                    A_MASK1:  mask1_q  <= reg_wdata;
                    A_POWER:  power_q  <= reg_wdata[7:0];
                    A_CLOCK:  clock_q  <= reg_wdata[7:0];
                    A_DCTRL:  dctrl_q  <= reg_wdata[7:0];
                    A_LENGTH: length_q <= reg_wdata[15:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/stat_irq_chk.sv
module stat_irq_chk
    import stat_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [EVT_W-1:0]  evt_set,
    input logic [EVT_W-1:0]  sticky_q,
    input logic [DATA_W-1:0] mask0_q,
    input logic              fifo_pop,
    input logic              hold_refill,
    input logic              irq0
);
    a_r5_enter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> hold_refill);

    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_refill && reg_rd && reg_addr == A_STATUS) |=> !hold_refill);

    a_r3_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        evt_set[0] |=> sticky_q[0]);

    a_r2_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CLEAR && reg_wdata[0] && !evt_set[0]) |=> !sticky_q[0]);

    a_r1_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask0_q == '0) |-> !irq0);

    a_r2_bit9_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sticky_q[9]);
endmodule

bind stat_irq_bank stat_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .evt_set(evt_set),
    .sticky_q(sticky_q), .mask0_q(mask0_q), .fifo_pop(fifo_pop),
    .hold_refill(hold_refill), .irq0(irq0)
);

// File: tb/sim_stat_irq_bank.sv
module sim_stat_irq_bank;
    localparam logic [63:0] IDB = 64'hC419_E77E_0001_3C5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [10:0] evt_set = '0;
    logic [10:0] lvl_flags = '0;
    logic [15:0] bytes_left = '0;
    logic [31:0] fifo_rdata = 32'hA5A5_0001;
    logic        fifo_pop, fifo_push, hold_refill, irq0, irq1;
    logic [31:0] fifo_wdata;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    stat_irq_bank u0 (.*);

    // behavioural reference
    int unsigned m_sticky, m_mask0, m_mask1, m_pow, m_clk, m_len, m_dc, m_rd;
    bit m_hold;
    string m_tag = "R9";

    function automatic bit in_win(int unsigned a);
        return a >= 'h80 && a <= 'hBC && a % 4 == 0;
    endfunction

    function automatic int unsigned rd_val(int unsigned a);
        int unsigned st;
        st = (int'(lvl_flags) << 11) | m_sticky;
        if (in_win(a)) return fifo_rdata;
        if (a >= 'hFE0) return (IDB >> (((a - 'hFE0) / 4) * 8)) & 'hFF;
        case (a)
            'h00: return m_pow;
            'h04: return m_clk;
            'h08: return m_len;
            'h0C: return m_dc;
            'h10: return st;
            'h18: return m_mask0;
            'h1C: return m_mask1;
            'h20: return (int'(bytes_left) + 3) / 4;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int unsigned a, clr;
        a = reg_addr;
        if (!rst_n) begin
            m_sticky = 0; m_mask0 = 0; m_mask1 = 0; m_pow = 0; m_clk = 0;
            m_len = 0; m_dc = 0; m_rd = 0; m_hold = 0; m_tag = "R9";
        end else begin
            clr = 0;
            if (reg_rd) begin
                m_rd = rd_val(a);
                if (in_win(a)) begin m_hold = 1; m_tag = "R8"; end
                else if (a == 'h10) begin m_hold = 0; m_tag = "R5"; end
                else if (a == 'h20) begin m_hold = 0; m_tag = "R4"; end
                else if (a >= 'hFE0) m_tag = "R6";
                else if (a <= 'h0C) m_tag = "R7";
                else m_tag = "R10";
            end
            if (reg_wr) begin
                case (a)
                    'h00: m_pow = reg_wdata & 'hFF;
                    'h04: m_clk = reg_wdata & 'hFF;
                    'h08: m_len = reg_wdata & 'hFFFF;
                    'h0C: m_dc = reg_wdata & 'hFF;
                    'h14: clr = reg_wdata & 'h7FF;
                    'h18: m_mask0 = reg_wdata;
                    'h1C: m_mask1 = reg_wdata;
                    default: ;
                endcase
            end
            // R3: set outranks clear; bit 9 has no source
            m_sticky = (m_sticky & ~clr) | (int'(evt_set) & 'h5FF);
        end
    end

    task automatic chk(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int unsigned st;
        #5;
        if (!done) begin
            st = (int'(lvl_flags) << 11) | m_sticky;
            chk("R1", "irq0", irq0, (st & m_mask0) != 0);
            chk("R1", "irq1", irq1, (st & m_mask1) != 0);
            chk("R5", "hold_refill", hold_refill, m_hold);
            chk(m_tag, "reg_rdata", reg_rdata, m_rd);
            chk("R8", "fifo_pop", fifo_pop, reg_rd && in_win(reg_addr));
            chk("R8", "fifo_push", fifo_push, reg_wr && in_win(reg_addr));
            if (fifo_push) chk("R8", "fifo_wdata", fifo_wdata, reg_wdata);
        end
    end

    task automatic wr(int unsigned a, int unsigned d);
        @(negedge clk); reg_wr = 1; reg_addr = 12'(a); reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(int unsigned a);
        @(negedge clk); reg_rd = 1; reg_addr = 12'(a);
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic pulse(logic [10:0] e);
        @(negedge clk); evt_set = e;
        @(negedge clk); evt_set = '0;
    endtask

    initial begin
        #(20 * 50000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R9", "irq0 after reset", irq0, 0);
        chk("R9", "rdata after reset", reg_rdata, 0);
        // R3, R1: sticky events and masks
        wr('h18, 32'h0000_0401);
        wr('h1C, 32'h0020_0000);
        pulse(11'h001);
        repeat (3) @(negedge clk);
        pulse(11'h600);                      // bit 9 must not stick (R2)
        rd('h10);
        lvl_flags = 11'h400;                 // status bit 21 -> irq1
        repeat (2) @(negedge clk);
        // R2: clear only selected bits, upper field untouched
        wr('h14, 32'hFFFF_F001);
        rd('h10);
        wr('h14, 32'h0000_0400);
        lvl_flags = '0;
        // R3: set and clear same bit same cycle
        pulse(11'h010);
        @(negedge clk); evt_set = 11'h010; reg_wr = 1; reg_addr = 12'h014; reg_wdata = 32'h10;
        @(negedge clk); evt_set = '0; reg_wr = 0;
        rd('h10);
        // R4: rounding
        foreach (bytes_left_vals[i]) begin
            bytes_left = bytes_left_vals[i];
            rd('h20);
        end
        // R7: truncation
        wr('h00, 32'h1FF); rd('h00);
        wr('h04, 32'hABCD); rd('h04);
        wr('h08, 32'h12345); rd('h08);
        wr('h0C, 32'h3F7); rd('h0C);
        // R6: id bytes
        for (int k = 0; k < 8; k++) rd('hFE0 + 4 * k);
        // R8, R5: FIFO window and deferral
        rd('h80);
        fifo_rdata = 32'h1234_5678;
        rd('h00);                            // must not release
        rd('hBC);
        rd('h10);                            // releases
        rd('h9C);
        bytes_left = 16'd9;
        rd('h20);                            // releases via count
        wr('h9C, 32'hDEAD_BEEF);
        wr('hA0, 32'h0BAD_F00D);
        // R10: unmapped and hold of rdata
        rd('h44);
        repeat (3) @(negedge clk);
        rd('h82);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    logic [15:0] bytes_left_vals [5] = '{16'd0, 16'd1, 16'd4, 16'd5, 16'hFFFF};
endmodule